// File: doc/BRIEF.md
# Quadrature mouse status interface

The block takes the raw two-channel quadrature outputs of a mouse's X and Y encoders and its three button contacts and presents them to a processor as two read-only status words on a small memory-mapped bus. It keeps no position counter. Each axis has a sticky step strobe, which is active low, and a direction bit. Software polls the movement word, adds or subtracts one step per axis when it sees the strobe, and keeps the position itself. Reading the movement word acknowledges the strobes. The button word also carries a fixed board revision code, so one read returns both button state and board identity.

Every asynchronous input goes through a two-flop synchroniser before any decoding. Each axis decoder compares the current synchronised A/B pair with the pair it saw one cycle earlier. A change of a single bit is one step, and its direction follows the Gray order. A change of both bits is treated as noise and dropped. The bus returns read data one cycle after the request. Writes to either address are taken and have no effect.

Top module: `mouse_qstat`

## Requirements
- R1: After reset the button word reads 0x0060 with no button pressed, and the movement word reads 0x0005: both step strobes are idle high and both direction bits are 0.
- R2: A read request (req_i=1, we_i=0) sampled on a clock edge gives rvalid_o=1 with the data on rdata_o for exactly the next cycle. Write requests and idle cycles give rvalid_o=0.
- R3: The button word (addr_i=0) is the revision code REV (default 0x60) ORed with the pressed state of right (bit 0), middle (bit 1) and left (bit 2). Bits 15:8 read 0.
- R4: A single-bit change of the X pair {x_a_i,x_b_i} along the order 00,01,11,10,00 drives movement bit 0 (X step strobe) to 0 and sets bit 1 (X direction) to 0, meaning increment.
- R5: A single-bit change of the X pair against that order drives bit 0 to 0 and sets bit 1 to 1, meaning decrement. When several steps come before a read, the direction of the last one is kept.
- R6: The Y pair behaves in the same way, with bit 2 as the Y step strobe (active low) and bit 3 as the Y direction. Bits 15:4 of the movement word read 0.
- R7: A read of the movement word (addr_i=1) returns the current strobes and then sets both strobes back to 1. Direction bits keep their values. If a new step arrives in the same cycle as the read, its strobe stays 0.
- R8: A change of both bits of an axis pair in one synchronised sample changes neither that axis's strobe nor its direction.
- R9: Writes to either address change no register bit and return no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_a_i | input | 1 | X encoder channel A, asynchronous |
| x_b_i | input | 1 | X encoder channel B, asynchronous |
| y_a_i | input | 1 | Y encoder channel A, asynchronous |
| y_b_i | input | 1 | Y encoder channel B, asynchronous |
| btn_right_i | input | 1 | Right button, 1 = pressed |
| btn_middle_i | input | 1 | Middle button, 1 = pressed |
| btn_left_i | input | 1 | Left button, 1 = pressed |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = button word, 1 = movement word |
| wdata_i | input | 16 | Write data (discarded) |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Read data |

## Verification
The X and Y pairs are driven through forward steps, reverse steps, back-to-back steps with no read between them, and a jump of both bits. These patterns separate increment from decrement, show that only the latest direction is kept, and show that a two-bit jump is dropped rather than counted. Movement reads are issued in pairs, so the first read shows the latched strobe and the second shows that the read set it back to idle while the direction bits stayed. Button combinations are read to check that each bit is in its own position and that the revision code is merged in. Writes carrying all ones are placed between a step and its read, to show that a write neither clears the strobe nor returns data.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int BUS_W = 16;
  localparam int N_AXES = 2;
  localparam int N_BTNS = 3;

  typedef enum logic {
    SEL_BTN = 1'b0,
    SEL_MOV = 1'b1
  } mq_sel_e;

  // Gray-order successor of an A/B pair: 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [1:0] gray_next(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_next = 2'b01;
      2'b01:   gray_next = 2'b11;
      2'b11:   gray_next = 2'b10;
      default: gray_next = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/mq_sync.sv
module mq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/mq_quad_dec.sv
module mq_quad_dec
  import mq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  output logic       step_o,
  output logic       dec_o,
  output logic       bad_o
);
  logic [1:0] prev_q;
  logic [1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= ab_i;
  end

  assign diff   = ab_i ^ prev_q;
  assign step_o = diff[0] ^ diff[1];
  assign bad_o  = &diff;
  // a forward move lands on the Gray successor of the previous pair
  assign dec_o  = (ab_i != gray_next(prev_q));
endmodule

// File: rtl/mq_axis_flag.sv
module mq_axis_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic step_n_o,
  output logic dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_n_o <= 1'b1;
      dir_o    <= 1'b0;
    end else begin
      if (step_i) begin
        step_n_o <= 1'b0;  // set wins over a clearing read
        dir_o    <= dec_i;
      end else if (clr_i) begin
        step_n_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mouse_qstat.sv
module mouse_qstat
  import mq_pkg::*;
#(
  parameter logic [7:0] REV = 8'h60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             x_a_i,
  input  logic             x_b_i,
  input  logic             y_a_i,
  input  logic             y_b_i,
  input  logic             btn_right_i,
  input  logic             btn_middle_i,
  input  logic             btn_left_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             rvalid_o,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int SYNC_W = 2 * N_AXES + N_BTNS;

  logic [SYNC_W-1:0] raw_in, sync_in;
  logic [N_BTNS-1:0] btn_s;
  logic [1:0]        ab_s [N_AXES];
  logic [N_AXES-1:0] ax_step, ax_dec, ax_bad, flag_n, flag_dir;
  logic              rd_req, mov_clr;
  logic [BUS_W-1:0]  btn_word, mov_word;
  logic              unused_wdata;

  assign raw_in = {btn_left_i, btn_middle_i, btn_right_i, y_a_i, y_b_i, x_a_i, x_b_i};

  mq_sync #(.W(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  assign btn_s = sync_in[SYNC_W-1 -: N_BTNS];

  assign rd_req  = req_i && !we_i;
  assign mov_clr = rd_req && (mq_sel_e'(addr_i) == SEL_MOV);

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    assign ab_s[g] = sync_in[2*g +: 2];

    mq_quad_dec u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ab_i   (ab_s[g]),
      .step_o (ax_step[g]),
      .dec_o  (ax_dec[g]),
      .bad_o  (ax_bad[g])
    );

    mq_axis_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (ax_step[g]),
      .dec_i    (ax_dec[g]),
      .clr_i    (mov_clr),
      .step_n_o (flag_n[g]),
      .dir_o    (flag_dir[g])
    );

    assign mov_word[2*g]   = flag_n[g];
    assign mov_word[2*g+1] = flag_dir[g];
  end

  assign mov_word[BUS_W-1:2*N_AXES] = '0;
  assign btn_word = {{(BUS_W-8){1'b0}}, REV | {{(8-N_BTNS){1'b0}}, btn_s}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= (mq_sel_e'(addr_i) == SEL_MOV) ? mov_word : btn_word;
    end
  end

  // write data is accepted and dropped
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/mq_checker.sv
module mq_checker #(
  parameter logic [7:0] REV = 8'h60
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        addr_i,
  input logic        rvalid_o,
  input logic [15:0] rdata_o,
  input logic        x_step,
  input logic        x_bad,
  input logic        x_flag_n,
  input logic        x_dir
);
  a_r2_rvalid_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r9_no_rvalid_else: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  a_r3_rev_merged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_i) |=> (((rdata_o[7:0] & REV) == REV) && (rdata_o[15:8] == 8'h00)));

  a_r6_mov_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i) |=> (rdata_o[15:4] == 12'h000));

  a_r4_step_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_step |=> !x_flag_n);

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i && !x_step) |=> x_flag_n);

  a_r8_double_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_bad && !(req_i && !we_i && addr_i)) |=> ($stable(x_flag_n) && $stable(x_dir)));

  a_r9_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !x_step) |=> ($stable(x_flag_n) && $stable(x_dir)));
endmodule

bind mouse_qstat mq_checker #(.REV(REV)) u_mq_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o),
  .x_step   (ax_step[0]),
  .x_bad    (ax_bad[0]),
  .x_flag_n (flag_n[0]),
  .x_dir    (flag_dir[0])
);

// File: tb/mouse_qstat_bench.sv
`timescale 1ns/1ps
module mouse_qstat_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xa = 0, xb = 0, ya = 0, yb = 0;
  logic br = 0, bm = 0, bl = 0;
  logic req = 0, we = 0, addr = 0;
  logic [15:0] wdata = '0;
  logic rvalid;
  logic [15:0] rdata;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  int xi = 0, yi = 0;
  logic [1:0] gseq [4] = '{2'b00, 2'b01, 2'b11, 2'b10};

  always #4 clk = ~clk;

  mouse_qstat u_mouse_qstat (
    .clk_i(clk), .rst_ni(rst_n),
    .x_a_i(xa), .x_b_i(xb), .y_a_i(ya), .y_b_i(yb),
    .btn_right_i(br), .btn_middle_i(bm), .btn_left_i(bl),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  // monitor: pops expected reads as data comes back
  always @(negedge clk) begin
    if (rst_n && !done && rvalid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R9: unexpected rvalid, actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_read(input logic a, input logic [15:0] e, input string t);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 0;
    @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: read data missing, actual none expected %h", e);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic move(input bit is_y, input int delta);
    @(negedge clk);
    if (is_y) begin
      yi = (yi + delta) & 3;
      {ya, yb} = gseq[yi];
    end else begin
      xi = (xi + delta) & 3;
      {xa, xb} = gseq[xi];
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_btn(input logic l, input logic m, input logic r);
    @(negedge clk);
    bl = l; bm = m; br = r;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    bus_read(0, 16'h0060, "R1 button word at reset");
    bus_read(1, 16'h0005, "R1 movement word at reset");

    set_btn(0, 0, 1);
    bus_read(0, 16'h0061, "R3 right button");
    set_btn(1, 1, 0);
    bus_read(0, 16'h0066, "R3 middle+left");
    set_btn(1, 1, 1);
    bus_read(0, 16'h0067, "R3 all buttons");

    move(0, 1);
    bus_read(1, 16'h0004, "R4 X forward step");
    bus_read(1, 16'h0005, "R7 X strobe cleared by read");

    move(0, -1);
    bus_read(1, 16'h0006, "R5 X reverse step");
    bus_read(1, 16'h0007, "R7 clear keeps X direction");

    move(1, 1);
    bus_read(1, 16'h0003, "R6 Y forward step");
    bus_read(1, 16'h0007, "R7 Y strobe cleared");

    move(1, -1);
    bus_read(1, 16'h000B, "R6 Y reverse step");
    bus_read(1, 16'h000F, "R7 Y clear keeps direction");

    move(0, 2);
    bus_read(1, 16'h000F, "R8 X double transition dropped");
    move(0, 1);
    bus_read(1, 16'h000C, "R4 X forward after double");
    bus_read(1, 16'h000D, "R7 clear after forward");

    move(0, 1);
    bus_write(1, 16'hFFFF);
    bus_write(0, 16'hFFFF);
    bus_read(1, 16'h000C, "R9 write leaves movement word");
    bus_read(0, 16'h0067, "R9 write leaves button word");

    move(0, -1);
    move(0, -1);
    bus_read(1, 16'h000E, "R5 two reverse steps before read");
    bus_read(1, 16'h000F, "R7 clear after two steps");

    set_btn(0, 0, 0);
    bus_read(0, 16'h0060, "R3 buttons released");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule